// File: doc/BRIEF.md
# Outer-Bank CHR Bank Generator

This block produces the 1 KiB CHR bank number that a multicart board drives towards its CHR memory for each PPU access. The inner bank controller holds six CHR bank registers and a half-swap bit. Two of those registers each cover a 2 KiB pair of slots. The other four each cover a single 1 KiB slot. The outer-bank configuration decides how much of the final bank number comes from those inner registers and how much comes from outer settings and the raw PPU address lines A12..A10.

The outer configuration selects one of four combinational modes:
- **MODE_INNER_DIRECT**: the usual inner pairing of registers to slots.
- **MODE_INNER_REMAP**: the paired slots take their register verbatim on the even half and yield zero on the odd half.
- **MODE_OUTER_DIRECT**: the bank is the outer nibble followed by the PPU address lines.
- **MODE_OUTER_REMAP**: as MODE_OUTER_DIRECT, except that the inner top bit is suppressed on the odd half of a pair.

Independently of the mode, a top-bit override replaces bank bit 7 with an outer bit. The mode follows the configuration inputs directly, with no clock. The only "transitions" are changes of `cfg_outer_mode` and `cfg_remap`:
- 00 selects INNER_DIRECT.
- 01 selects INNER_REMAP.
- 10 selects OUTER_DIRECT.
- 11 selects OUTER_REMAP.

Top module: `chr_outer_bank`

## Requirements
- R1: In MODE_INNER_DIRECT with the half-swap bit clear, the effective slot equals `ppu_a`. Slot 0 gives register 0 with bit 0 cleared. Slot 1 gives register 0 with bit 0 set. Slot 2 gives register 1 with bit 0 cleared. Slot 3 gives register 1 with bit 0 set. Slots 4..7 give registers 2..5. Register k sits at `inner_chr_regs[k]`.
- R2: A set `inner_chr_swap` bit inverts bit 2 of the slot number before the register is chosen, which swaps the two 4 KiB halves.
- R3: In MODE_INNER_REMAP, effective slots 0 and 2 give registers 0 and 1 unmodified. Effective slots 1 and 3 give zero in bits 6..0, and also in bit 7 unless the override is active. Effective slots 4..7 behave as in R1.
- R4: In either outer mode, bank bits 6..3 equal `cfg_chr_outer[3:0]`.
- R5: In either outer mode, bank bits 2..0 equal `ppu_a`, whatever the inner registers hold.
- R6: With `cfg_chr_top_sel` = 1, bank bit 7 equals `cfg_chr_top_alt` in every mode.
- R7: With `cfg_chr_top_sel` = 0 in MODE_OUTER_DIRECT, bank bit 7 equals bit 7 of the register that MODE_INNER_DIRECT would pick for the same effective slot.
- R8: In MODE_OUTER_REMAP with `cfg_chr_top_sel` = 0, bank bit 7 is 0 on effective slots 1 and 3. It follows R7 on all other slots.
- R9: The output follows any input change without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_outer_mode | input | 1 | 1 selects the outer modes (nibble plus PPU lines) |
| cfg_remap | input | 1 | 1 selects the remapped variant of the current mode |
| cfg_chr_top_sel | input | 1 | 1 takes bank bit 7 from `cfg_chr_top_alt` |
| cfg_chr_top_alt | input | 1 | Alternate value for bank bit 7 |
| cfg_chr_outer | input | 4 | Outer nibble for bank bits 6..3 in the outer modes |
| inner_chr_regs | input | 6x8 | Inner CHR bank registers 0..5, packed, register k at [k] |
| inner_chr_swap | input | 1 | Inner half-swap bit, inverts slot bit 2 |
| ppu_a | input | 3 | PPU address lines A12..A10 |
| chr_bank | output | 8 | 1 KiB CHR bank number |

## Verification
The bench builds the block with its default parameters: an 8-bit bank number and a 3-bit slot field, which gives eight slots and six inner registers. At that size it can sweep every slot against every combination of mode, half-swap and override against a model of the requirements. The sweep covers both halves of both 2 KiB pairs and the suppression of the top bit on odd pair halves. Directed steps then show that the outer modes ignore the inner registers, and that the output moves between clock edges when only the PPU lines change.

// File: rtl/chr_outer_pkg.sv
package chr_outer_pkg;

    typedef enum logic [1:0] {
        MODE_INNER_DIRECT = 2'b00,
        MODE_INNER_REMAP  = 2'b01,
        MODE_OUTER_DIRECT = 2'b10,
        MODE_OUTER_REMAP  = 2'b11
    } chr_mode_e;

endpackage

// File: rtl/chr_slot_map.sv
module chr_slot_map #(
    parameter int SLOT_W = 3
) (
    input  logic [SLOT_W-1:0] ppu_a,
    input  logic              swap,
    output logic [SLOT_W-1:0] eff_slot,
    output logic              odd_half
);

    localparam logic [SLOT_W-1:0] SWAP_MASK = {1'b1, {(SLOT_W-1){1'b0}}};

    always_comb begin
        eff_slot = swap ? (ppu_a ^ SWAP_MASK) : ppu_a;
        // lower half holds the 2 KiB pairs; bit 0 picks the half of a pair
        odd_half = ~eff_slot[SLOT_W-1] & eff_slot[0];
    end

endmodule

// File: rtl/chr_inner_pick.sv
module chr_inner_pick #(
    parameter int BANK_W = 8,
    parameter int SLOT_W = 3,
    localparam int SLOT_CNT = 1 << SLOT_W,
    localparam int PAIR_SLOTS = SLOT_CNT / 2,
    localparam int PAIR_REGS = SLOT_CNT / 4,
    localparam int REG_CNT = PAIR_REGS + PAIR_SLOTS
) (
    input  logic [REG_CNT-1:0][BANK_W-1:0] regs,
    input  logic [SLOT_W-1:0]              eff_slot,
    output logic [BANK_W-1:0]              direct_val,
    output logic [BANK_W-1:0]              remap_val
);

    logic [SLOT_CNT-1:0][BANK_W-1:0] cand_direct;
    logic [SLOT_CNT-1:0][BANK_W-1:0] cand_remap;

    for (genvar g = 0; g < SLOT_CNT; g++) begin : g_slot
        if (g < PAIR_SLOTS) begin : g_pair
            assign cand_direct[g] = {regs[g/2][BANK_W-1:1], 1'(g % 2)};
            if (g % 2 == 0) begin : g_even
                assign cand_remap[g] = regs[g/2];
            end else begin : g_odd
                assign cand_remap[g] = '0;
            end
        end else begin : g_single
            assign cand_direct[g] = regs[g - PAIR_SLOTS + PAIR_REGS];
            assign cand_remap[g]  = regs[g - PAIR_SLOTS + PAIR_REGS];
        end
    end

    always_comb begin
        direct_val = cand_direct[eff_slot];
        remap_val  = cand_remap[eff_slot];
    end

endmodule

// File: rtl/chr_bank_compose.sv
module chr_bank_compose
    import chr_outer_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int SLOT_W = 3,
    localparam int OUTER_W = BANK_W - 1 - SLOT_W
) (
    input  chr_mode_e          mode,
    input  logic [BANK_W-1:0]  direct_val,
    input  logic [BANK_W-1:0]  remap_val,
    input  logic               odd_half,
    input  logic [OUTER_W-1:0] outer_nib,
    input  logic [SLOT_W-1:0]  ppu_a,
    input  logic               top_sel,
    input  logic               top_alt,
    output logic [BANK_W-1:0]  bank
);

    logic [BANK_W-1:0] raw;

    always_comb begin
        raw = direct_val;
        unique case (mode)
            MODE_INNER_DIRECT: raw = direct_val;
            MODE_INNER_REMAP:  raw = remap_val;
            MODE_OUTER_DIRECT: raw = {direct_val[BANK_W-1], outer_nib, ppu_a};
            MODE_OUTER_REMAP:  raw = {direct_val[BANK_W-1] & ~odd_half, outer_nib, ppu_a};
        endcase
    end

    always_comb begin
        bank = {top_sel ? top_alt : raw[BANK_W-1], raw[BANK_W-2:0]};
    end

endmodule

// File: rtl/chr_outer_bank.sv
module chr_outer_bank
    import chr_outer_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int SLOT_W = 3,
    localparam int SLOT_CNT = 1 << SLOT_W,
    localparam int REG_CNT = SLOT_CNT / 4 + SLOT_CNT / 2,
    localparam int OUTER_W = BANK_W - 1 - SLOT_W
) (
    input  logic                           cfg_outer_mode,
    input  logic                           cfg_remap,
    input  logic                           cfg_chr_top_sel,
    input  logic                           cfg_chr_top_alt,
    input  logic [OUTER_W-1:0]             cfg_chr_outer,
    input  logic [REG_CNT-1:0][BANK_W-1:0] inner_chr_regs,
    input  logic                           inner_chr_swap,
    input  logic [SLOT_W-1:0]              ppu_a,
    output logic [BANK_W-1:0]              chr_bank
);

    chr_mode_e         mode;
    logic [SLOT_W-1:0] eff_slot;
    logic              odd_half;
    logic [BANK_W-1:0] direct_val;
    logic [BANK_W-1:0] remap_val;

    always_comb begin
        mode = MODE_INNER_DIRECT;
        unique case ({cfg_outer_mode, cfg_remap})
            2'b00: mode = MODE_INNER_DIRECT;
            2'b01: mode = MODE_INNER_REMAP;
            2'b10: mode = MODE_OUTER_DIRECT;
            2'b11: mode = MODE_OUTER_REMAP;
        endcase
    end

    chr_slot_map #(.SLOT_W(SLOT_W)) u_slot_map (
        .ppu_a    (ppu_a),
        .swap     (inner_chr_swap),
        .eff_slot (eff_slot),
        .odd_half (odd_half)
    );

    chr_inner_pick #(.BANK_W(BANK_W), .SLOT_W(SLOT_W)) u_inner_pick (
        .regs       (inner_chr_regs),
        .eff_slot   (eff_slot),
        .direct_val (direct_val),
        .remap_val  (remap_val)
    );

    chr_bank_compose #(.BANK_W(BANK_W), .SLOT_W(SLOT_W)) u_compose (
        .mode       (mode),
        .direct_val (direct_val),
        .remap_val  (remap_val),
        .odd_half   (odd_half),
        .outer_nib  (cfg_chr_outer),
        .ppu_a      (ppu_a),
        .top_sel    (cfg_chr_top_sel),
        .top_alt    (cfg_chr_top_alt),
        .bank       (chr_bank)
    );

endmodule

// File: rtl/chr_outer_bank_chk.sv
module chr_outer_bank_chk #(
    parameter int BANK_W = 8,
    parameter int SLOT_W = 3,
    localparam int OUTER_W = BANK_W - 1 - SLOT_W
) (
    input logic               cfg_outer_mode,
    input logic               cfg_remap,
    input logic               cfg_chr_top_sel,
    input logic               cfg_chr_top_alt,
    input logic [OUTER_W-1:0] cfg_chr_outer,
    input logic               inner_chr_swap,
    input logic [SLOT_W-1:0]  ppu_a,
    input logic [BANK_W-1:0]  chr_bank
);

    logic [SLOT_W-1:0] slot_c;
    logic              odd_c;

    always_comb begin
        slot_c = ppu_a ^ {inner_chr_swap, {(SLOT_W-1){1'b0}}};
        odd_c  = ~slot_c[SLOT_W-1] & slot_c[0];
        if (!$isunknown({cfg_outer_mode, cfg_remap, cfg_chr_top_sel, cfg_chr_top_alt,
                         cfg_chr_outer, inner_chr_swap, ppu_a, chr_bank})) begin
            AST_OUTER_NIBBLE: assert (!cfg_outer_mode || chr_bank[BANK_W-2:SLOT_W] == cfg_chr_outer); // R4
            AST_OUTER_PPU_LINES: assert (!cfg_outer_mode || chr_bank[SLOT_W-1:0] == ppu_a); // R5
            AST_TOP_OVERRIDE: assert (!cfg_chr_top_sel || chr_bank[BANK_W-1] == cfg_chr_top_alt); // R6
            AST_REMAP_ODD_ZERO: assert (cfg_outer_mode || !cfg_remap || !odd_c
                                        || chr_bank[BANK_W-2:0] == '0); // R3
            AST_PAIR_PARITY: assert (cfg_outer_mode || cfg_remap || slot_c[SLOT_W-1]
                                     || chr_bank[0] == slot_c[0]); // R1
            AST_OUTER_REMAP_TOP: assert (!(cfg_outer_mode && cfg_remap && !cfg_chr_top_sel && odd_c)
                                         || !chr_bank[BANK_W-1]); // R8
        end
    end

endmodule

bind chr_outer_bank chr_outer_bank_chk #(.BANK_W(BANK_W), .SLOT_W(SLOT_W)) u_chk (
    .cfg_outer_mode  (cfg_outer_mode),
    .cfg_remap       (cfg_remap),
    .cfg_chr_top_sel (cfg_chr_top_sel),
    .cfg_chr_top_alt (cfg_chr_top_alt),
    .cfg_chr_outer   (cfg_chr_outer),
    .inner_chr_swap  (inner_chr_swap),
    .ppu_a           (ppu_a),
    .chr_bank        (chr_bank)
);

// File: tb/test_chr_outer_bank.sv
module test_chr_outer_bank;

    localparam logic [5:0][7:0] REGS = {8'h0F, 8'hE2, 8'h5C, 8'h91, 8'h37, 8'hA4};

    // mode[23:22] swap[21] sel[20] alt[19] nib[18:15] a[14:12] exp[11:4] req[3:0]
    localparam int NVEC = 17;
    localparam logic [23:0] VECS [NVEC] = '{
        {2'b00, 1'b0, 1'b0, 1'b0, 4'h0, 3'd0, 8'hA4, 4'd1},
        {2'b00, 1'b0, 1'b0, 1'b0, 4'h0, 3'd1, 8'hA5, 4'd1},
        {2'b00, 1'b0, 1'b0, 1'b0, 4'h0, 3'd3, 8'h37, 4'd1},
        {2'b00, 1'b0, 1'b0, 1'b0, 4'h0, 3'd5, 8'h5C, 4'd1},
        {2'b00, 1'b1, 1'b0, 1'b0, 4'h0, 3'd0, 8'h91, 4'd2},
        {2'b00, 1'b1, 1'b0, 1'b0, 4'h0, 3'd6, 8'h36, 4'd2},
        {2'b01, 1'b0, 1'b0, 1'b0, 4'h0, 3'd1, 8'h00, 4'd3},
        {2'b01, 1'b0, 1'b0, 1'b0, 4'h0, 3'd2, 8'h37, 4'd3},
        {2'b01, 1'b0, 1'b0, 1'b0, 4'h0, 3'd0, 8'hA4, 4'd3},
        {2'b10, 1'b0, 1'b0, 1'b0, 4'hA, 3'd5, 8'h55, 4'd4},
        {2'b10, 1'b0, 1'b0, 1'b0, 4'h3, 3'd2, 8'h1A, 4'd5},
        {2'b10, 1'b1, 1'b0, 1'b0, 4'h3, 3'd2, 8'h9A, 4'd7},
        {2'b00, 1'b0, 1'b1, 1'b0, 4'h0, 3'd6, 8'h62, 4'd6},
        {2'b10, 1'b0, 1'b1, 1'b1, 4'hF, 3'd7, 8'hFF, 4'd6},
        {2'b11, 1'b0, 1'b0, 1'b0, 4'h5, 3'd1, 8'h29, 4'd8},
        {2'b11, 1'b0, 1'b0, 1'b0, 4'h5, 3'd0, 8'hA8, 4'd8},
        {2'b01, 1'b0, 1'b1, 1'b1, 4'h0, 3'd3, 8'h80, 4'd6}
    };

    logic            clk = 1'b0;
    logic            cfg_outer_mode = 1'b0;
    logic            cfg_remap = 1'b0;
    logic            cfg_chr_top_sel = 1'b0;
    logic            cfg_chr_top_alt = 1'b0;
    logic [3:0]      cfg_chr_outer = '0;
    logic [5:0][7:0] inner_chr_regs = '0;
    logic            inner_chr_swap = 1'b0;
    logic [2:0]      ppu_a = '0;
    logic [7:0]      chr_bank;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    chr_outer_bank i_chr_outer_bank (
        .cfg_outer_mode  (cfg_outer_mode),
        .cfg_remap       (cfg_remap),
        .cfg_chr_top_sel (cfg_chr_top_sel),
        .cfg_chr_top_alt (cfg_chr_top_alt),
        .cfg_chr_outer   (cfg_chr_outer),
        .inner_chr_regs  (inner_chr_regs),
        .inner_chr_swap  (inner_chr_swap),
        .ppu_a           (ppu_a),
        .chr_bank        (chr_bank)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] mode, input logic swap, input logic sel,
                         input logic alt, input logic [3:0] nib, input logic [2:0] a);
        @(negedge clk);
        {cfg_outer_mode, cfg_remap} = mode;
        inner_chr_swap  = swap;
        cfg_chr_top_sel = sel;
        cfg_chr_top_alt = alt;
        cfg_chr_outer   = nib;
        ppu_a           = a;
        #2;
    endtask

    function automatic logic [7:0] model(input logic [1:0] mode, input logic swap,
                                         input logic sel, input logic alt,
                                         input logic [3:0] nib, input logic [2:0] a);
        logic [2:0] s;
        logic [7:0] dir;
        logic [7:0] rem;
        logic [7:0] res;
        s = a ^ {swap, 2'b00};
        if (!s[2]) begin
            dir = {REGS[s >> 1][7:1], s[0]};
            rem = s[0] ? 8'h00 : REGS[s >> 1];
        end else begin
            dir = REGS[s - 3'd2];
            rem = REGS[s - 3'd2];
        end
        case (mode)
            2'b00: res = dir;
            2'b01: res = rem;
            2'b10: res = {dir[7], nib, a};
            default: res = {dir[7] & ~(!s[2] && s[0]), nib, a};
        endcase
        if (sel) res[7] = alt;
        return res;
    endfunction

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // idle: all inputs zero gives bank 0 (R1)
        repeat (2) @(negedge clk);
        #2;
        check("R1 idle all-zero", chr_bank, 8'h00);

        inner_chr_regs = REGS;

        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i][23:22], VECS[i][21], VECS[i][20], VECS[i][19],
                  VECS[i][18:15], VECS[i][14:12]);
            check($sformatf("R%0d vector %0d", VECS[i][3:0], i), chr_bank, VECS[i][11:4]);
        end

        // sweep: every slot in every mode, swap and override setting
        for (int m = 0; m < 4; m++) begin
            for (int sw = 0; sw < 2; sw++) begin
                for (int sl = 0; sl < 2; sl++) begin
                    for (int a = 0; a < 8; a++) begin
                        logic [2:0] av;
                        logic       alt;
                        logic [3:0] nib;
                        string      tag;
                        av  = 3'(a);
                        alt = av[0] ^ sw[0];
                        nib = 4'(a + 5);
                        if (sl != 0) tag = "R6";
                        else if (m == 3) tag = "R8";
                        else if (m == 2) tag = "R4/R7";
                        else if (m == 1) tag = "R3";
                        else if (sw != 0) tag = "R2";
                        else tag = "R1";
                        apply(2'(m), sw[0], sl[0], alt, nib, av);
                        check($sformatf("%s sweep m=%0d sw=%0d sel=%0d a=%0d", tag, m, sw, sl, a),
                              chr_bank, model(2'(m), sw[0], sl[0], alt, nib, av));
                    end
                end
            end
        end

        // R5: outer mode ignores inner registers (override set so bit 7 is outer too)
        apply(2'b10, 1'b0, 1'b1, 1'b0, 4'h6, 3'd3);
        check("R5 before register change", chr_bank, 8'h33);
        inner_chr_regs = ~REGS;
        #1;
        check("R5 after register change", chr_bank, 8'h33);
        inner_chr_regs = REGS;

        // R9: output follows ppu_a between clock edges
        apply(2'b10, 1'b0, 1'b1, 1'b1, 4'h2, 3'd0);
        check("R9 first address", chr_bank, 8'h90);
        ppu_a = 3'd6;
        #1;
        check("R9 address change without edge", chr_bank, 8'h96);
        inner_chr_swap = 1'b1;
        cfg_outer_mode = 1'b0;
        cfg_chr_top_sel = 1'b0;
        #1;
        check("R9 mode change without edge", chr_bank, 8'h36);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule